// File: doc/BRIEF.md
# Dual-Master Per-Target Access Arbiter

This block sits between two bus masters, a processor and a DMA engine, and four target slaves on a layered interconnect. The targets are the on-chip RAM, the peripheral bus, the external memory bridge and the USB function. Each master presents a request, a target index, an address, write data and a write flag. The block returns a grant to each master. It steers each granted access onto the selected target's port, and it returns that target's completion and read data to the master that owns it.

Contention is resolved separately for each target, not for the interconnect as a whole. The two masters therefore run side by side whenever their target indices differ. When they name the same free target in the same cycle, the processor wins and the DMA engine waits. Grants are combinational. Ownership of a target is registered once a multi-cycle access has begun, and it is held until the target reports completion, so a late processor request never cuts into a DMA access already under way. A DMA transfer is a read phase followed by a write phase. Because the block adds no idle cycles, an uncontended transfer lasts exactly the sum of the two phase lengths.

Top module: `dual_master_xbar_arb`

## Requirements
- R1: While reset is high, and after reset with no requests, both grants, both done flags and every target valid bit are 0.
- R2: When both masters request and their target indices differ (and neither target is held by the other master), both are granted in the same cycle and each target port carries its own master's address, write data and write flag.
- R3: When both masters request the same target and no access is held on it, the processor (cpu_*) is granted and the DMA engine is not.
- R4: A stalled DMA request that holds its target, address and data is granted in the first cycle in which the processor no longer requests that target and the target is not held.
- R5: Once a master is granted a target and the target has not signalled done, that master keeps the target in every following cycle in which it still requests it; a request from the other master to that target is not granted meanwhile, even from the processor.
- R6: No target is ever driven by both masters in one cycle: the number of set slv_vld bits equals the number of asserted grants, and slv_owner bit s is 1 exactly when the DMA engine drives target s.
- R7: A master's done flag is high only in a cycle in which it is granted and its selected target asserts slv_done; its rdata is that target's slv_rdata.
- R8: Target index encoding: 0 = RAM, 1 = peripheral bus, 2 = external bridge, 3 = USB; these four are the only targets, and slave port s in every flattened vector is the slice [s*W +: W].
- R9: An uncontended target is granted in the same cycle as the request. A new request presented in the cycle after done is granted at once. A DMA transfer of a 2-cycle RAM read then a 1-cycle USB write therefore occupies exactly 3 cycles.
- R10: A held target is released in the cycle after it signals done, or as soon as its owner stops requesting it, so that the other master can be granted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_sel | input | SW | Processor target index |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_we | input | 1 | Processor write flag |
| cpu_gnt | output | 1 | Processor grant |
| cpu_done | output | 1 | Processor access complete |
| cpu_rdata | output | DW | Read data to processor |
| dma_req | input | 1 | DMA access request |
| dma_sel | input | SW | DMA target index |
| dma_addr | input | AW | DMA address |
| dma_wdata | input | DW | DMA write data |
| dma_we | input | 1 | DMA write flag |
| dma_gnt | output | 1 | DMA grant |
| dma_done | output | 1 | DMA access complete |
| dma_rdata | output | DW | Read data to DMA |
| slv_vld | output | NSLV | Per-target access valid |
| slv_owner | output | NSLV | Per-target owner, 1 = DMA |
| slv_we | output | NSLV | Per-target write flag |
| slv_addr | output | NSLV*AW | Per-target address, flattened |
| slv_wdata | output | NSLV*DW | Per-target write data, flattened |
| slv_done | input | NSLV | Per-target completion |
| slv_rdata | input | NSLV*DW | Per-target read data, flattened |

## Verification
Four patterns separate the arbitration cases. The first has the two masters on disjoint targets, which shows both grants in the same cycle and the routing on each port. The second has both masters arriving together on one free target, which shows processor priority and the DMA waiting until the processor leaves. The third has the processor arriving while the DMA engine already holds a three-cycle access, which shows that ownership is kept and that the grant passes back without a gap. A DMA read-then-write run next to an unrelated processor access measures the three-cycle transfer sum. A final case, in which an owner abandons its target, shows that release does not wait on a completion that never comes.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  // Target index encoding (R8)
  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_PER = 2'd1,
    TGT_EXT = 2'd2,
    TGT_USB = 2'd3
  } tgt_e;

  localparam int NMST    = 2;
  localparam int MST_CPU = 0;
  localparam int MST_DMA = 1;
endpackage

// File: rtl/dmx_grant.sv
module dmx_grant
  import dmx_pkg::*;
#(
  parameter int NSLV = 4,
  parameter int SW   = $clog2(NSLV)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NMST-1:0]           req,
  input  logic [NMST-1:0][SW-1:0]   sel,
  input  logic [NSLV-1:0]           lock_vld,
  input  logic [NSLV-1:0]           lock_own,
  output logic [NMST-1:0]           gnt
);
  logic [NMST-1:0] blocked;
  logic            same_tgt;

  assign same_tgt = (sel[MST_CPU] == sel[MST_DMA]);

  // A master is blocked when its target is held by the other master
  // and that owner is still asking for it.
  always_comb begin
    for (int m = 0; m < NMST; m++) begin
      blocked[m] = lock_vld[sel[m]]
                && (lock_own[sel[m]] != 1'(m))
                && req[NMST-1-m]
                && same_tgt;
    end
  end

  always_comb begin
    gnt[MST_CPU] = req[MST_CPU] && !blocked[MST_CPU];
    gnt[MST_DMA] = req[MST_DMA] && !blocked[MST_DMA]
                && !(gnt[MST_CPU] && same_tgt);
  end

  AST_CPU_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (req[MST_CPU] && req[MST_DMA] && same_tgt && !lock_vld[sel[MST_CPU]])
      |-> (gnt[MST_CPU] && !gnt[MST_DMA])); // R3

  AST_NO_SHARED_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(gnt[MST_CPU] && gnt[MST_DMA] && same_tgt)); // R6
endmodule

// File: rtl/dmx_lock.sv
module dmx_lock
#(
  parameter int NSLV = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSLV-1:0] slv_vld,
  input  logic [NSLV-1:0] slv_owner,
  input  logic [NSLV-1:0] slv_done,
  output logic [NSLV-1:0] lock_vld,
  output logic [NSLV-1:0] lock_own
);
  for (genvar s = 0; s < NSLV; s++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst) begin
        lock_vld[s] <= 1'b0;
        lock_own[s] <= 1'b0;
      end else begin
        lock_vld[s] <= slv_vld[s] && !slv_done[s];
        lock_own[s] <= slv_owner[s];
      end
    end
  end
endmodule

// File: rtl/dmx_route.sv
module dmx_route
  import dmx_pkg::*;
#(
  parameter int NSLV = 4,
  parameter int SW   = $clog2(NSLV),
  parameter int AW   = 16,
  parameter int DW   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NMST-1:0]           gnt,
  input  logic [NMST-1:0][SW-1:0]   sel,
  input  logic [NMST-1:0][AW-1:0]   addr,
  input  logic [NMST-1:0][DW-1:0]   wdata,
  input  logic [NMST-1:0]           we,
  output logic [NMST-1:0]           m_done,
  output logic [NMST-1:0][DW-1:0]   m_rdata,
  output logic [NSLV-1:0]           slv_vld,
  output logic [NSLV-1:0]           slv_owner,
  output logic [NSLV-1:0]           slv_we,
  output logic [NSLV-1:0][AW-1:0]   slv_addr,
  output logic [NSLV-1:0][DW-1:0]   slv_wdata,
  input  logic [NSLV-1:0]           slv_done,
  input  logic [NSLV-1:0][DW-1:0]   slv_rdata
);
  for (genvar s = 0; s < NSLV; s++) begin : g_tgt
    logic hit_c, hit_d;
    assign hit_c = gnt[MST_CPU] && (sel[MST_CPU] == SW'(s));
    assign hit_d = gnt[MST_DMA] && (sel[MST_DMA] == SW'(s));

    assign slv_vld[s]   = hit_c || hit_d;
    assign slv_owner[s] = hit_d;
    assign slv_we[s]    = hit_d ? we[MST_DMA]    : (hit_c && we[MST_CPU]);
    assign slv_addr[s]  = hit_d ? addr[MST_DMA]  : addr[MST_CPU];
    assign slv_wdata[s] = hit_d ? wdata[MST_DMA] : wdata[MST_CPU];
  end

  for (genvar m = 0; m < NMST; m++) begin : g_ret
    assign m_done[m]  = gnt[m] && slv_done[sel[m]];
    assign m_rdata[m] = slv_rdata[sel[m]];
  end

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $countones(slv_vld) == $countones(gnt)); // R6

  AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    m_done[MST_DMA] |-> slv_vld[sel[MST_DMA]] && slv_owner[sel[MST_DMA]]); // R7
endmodule

// File: rtl/dual_master_xbar_arb.sv
module dual_master_xbar_arb
  import dmx_pkg::*;
#(
  parameter int NSLV = 4,
  parameter int AW   = 16,
  parameter int DW   = 32,
  localparam int SW  = $clog2(NSLV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic [SW-1:0]      cpu_sel,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  input  logic               cpu_we,
  output logic               cpu_gnt,
  output logic               cpu_done,
  output logic [DW-1:0]      cpu_rdata,
  input  logic               dma_req,
  input  logic [SW-1:0]      dma_sel,
  input  logic [AW-1:0]      dma_addr,
  input  logic [DW-1:0]      dma_wdata,
  input  logic               dma_we,
  output logic               dma_gnt,
  output logic               dma_done,
  output logic [DW-1:0]      dma_rdata,
  output logic [NSLV-1:0]    slv_vld,
  output logic [NSLV-1:0]    slv_owner,
  output logic [NSLV-1:0]    slv_we,
  output logic [NSLV*AW-1:0] slv_addr,
  output logic [NSLV*DW-1:0] slv_wdata,
  input  logic [NSLV-1:0]    slv_done,
  input  logic [NSLV*DW-1:0] slv_rdata
);
  logic [NMST-1:0]          req, gnt, we, m_done;
  logic [NMST-1:0][SW-1:0]  sel;
  logic [NMST-1:0][AW-1:0]  addr;
  logic [NMST-1:0][DW-1:0]  wdata, m_rdata;
  logic [NSLV-1:0]          lock_vld, lock_own;

  assign req   = {dma_req, cpu_req};
  assign sel   = {dma_sel, cpu_sel};
  assign addr  = {dma_addr, cpu_addr};
  assign wdata = {dma_wdata, cpu_wdata};
  assign we    = {dma_we, cpu_we};

  dmx_grant #(.NSLV(NSLV), .SW(SW)) u_grant (
    .clk(clk), .rst(rst), .req(req), .sel(sel),
    .lock_vld(lock_vld), .lock_own(lock_own), .gnt(gnt)
  );

  dmx_route #(.NSLV(NSLV), .SW(SW), .AW(AW), .DW(DW)) u_route (
    .clk(clk), .rst(rst), .gnt(gnt), .sel(sel), .addr(addr),
    .wdata(wdata), .we(we), .m_done(m_done), .m_rdata(m_rdata),
    .slv_vld(slv_vld), .slv_owner(slv_owner), .slv_we(slv_we),
    .slv_addr(slv_addr), .slv_wdata(slv_wdata),
    .slv_done(slv_done), .slv_rdata(slv_rdata)
  );

  dmx_lock #(.NSLV(NSLV)) u_lock (
    .clk(clk), .rst(rst), .slv_vld(slv_vld), .slv_owner(slv_owner),
    .slv_done(slv_done), .lock_vld(lock_vld), .lock_own(lock_own)
  );

  assign cpu_gnt   = gnt[MST_CPU];
  assign dma_gnt   = gnt[MST_DMA];
  assign cpu_done  = m_done[MST_CPU];
  assign dma_done  = m_done[MST_DMA];
  assign cpu_rdata = m_rdata[MST_CPU];
  assign dma_rdata = m_rdata[MST_DMA];

  AST_DMA_KEEPS_TARGET: assert property (@(posedge clk) disable iff (rst)
    (dma_gnt && !dma_done) |=> (!dma_req || !$stable(dma_sel) || dma_gnt)); // R5

  AST_CPU_KEEPS_TARGET: assert property (@(posedge clk) disable iff (rst)
    (cpu_gnt && !cpu_done) |=> (!cpu_req || !$stable(cpu_sel) || cpu_gnt)); // R5

  AST_DMA_RESUMES: assert property (@(posedge clk) disable iff (rst)
    (cpu_done && dma_req && !dma_gnt && (cpu_sel == dma_sel))
      |=> (!dma_req || cpu_req || !$stable(dma_sel) || dma_gnt)); // R4
endmodule

// File: tb/dual_master_xbar_arb_test.sv
module dual_master_xbar_arb_test;
  localparam int PER  = 10;
  localparam int NSLV = 4;
  localparam int AW   = 16;
  localparam int DW   = 32;

  logic clk = 1'b0;
  logic rst;
  logic cpu_req, dma_req, cpu_we, dma_we;
  logic [1:0] cpu_sel, dma_sel;
  logic [AW-1:0] cpu_addr, dma_addr;
  logic [DW-1:0] cpu_wdata, dma_wdata, cpu_rdata, dma_rdata;
  logic cpu_gnt, dma_gnt, cpu_done, dma_done;
  logic [NSLV-1:0] slv_vld, slv_owner, slv_we, slv_done;
  logic [NSLV*AW-1:0] slv_addr;
  logic [NSLV*DW-1:0] slv_wdata, slv_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;

  dual_master_xbar_arb #(.NSLV(NSLV), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_gnt(cpu_gnt),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .dma_req(dma_req), .dma_sel(dma_sel), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_we(dma_we), .dma_gnt(dma_gnt),
    .dma_done(dma_done), .dma_rdata(dma_rdata),
    .slv_vld(slv_vld), .slv_owner(slv_owner), .slv_we(slv_we),
    .slv_addr(slv_addr), .slv_wdata(slv_wdata),
    .slv_done(slv_done), .slv_rdata(slv_rdata)
  );

  // Target models: RAM read 2 / write 1, peripheral 3, external 3, USB 1
  logic [NSLV-1:0][1:0] cnt;

  function automatic int lat(int s, logic w);
    case (s)
      0: return w ? 1 : 2;
      1: return 3;
      2: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic logic [DW-1:0] rd_val(int s, logic [AW-1:0] a);
    return {6'd0, 2'(s), 8'h00, a};
  endfunction

  always_comb begin
    for (int s = 0; s < NSLV; s++) begin
      slv_done[s] = slv_vld[s] && (int'(cnt[s]) == lat(s, slv_we[s]) - 1);
      slv_rdata[s*DW +: DW] = rd_val(s, slv_addr[s*AW +: AW]);
    end
  end

  always @(posedge clk) begin
    for (int s = 0; s < NSLV; s++)
      cnt[s] <= (rst || !slv_vld[s] || slv_done[s]) ? 2'd0 : cnt[s] + 2'd1;
  end

  typedef struct {
    string tag;
    logic cg, dg, cd, dd;
    logic [3:0] vld, own;
    logic [1:0] cs, ds;
    logic cw, dw;
    logic [AW-1:0] ca, da;
  } item_t;

  item_t q[$];

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wd(logic [AW-1:0] a);
    return ~{16'h0, a};
  endfunction

  task automatic cyc(string tag,
                     logic cr, logic [1:0] cs, logic cw, logic [AW-1:0] ca,
                     logic dr, logic [1:0] ds, logic dw, logic [AW-1:0] da,
                     logic cg, logic dg, logic cd, logic dd,
                     logic [3:0] vld, logic [3:0] own);
    item_t it;
    @(negedge clk);
    cpu_req = cr; cpu_sel = cs; cpu_we = cw; cpu_addr = ca; cpu_wdata = wd(ca);
    dma_req = dr; dma_sel = ds; dma_we = dw; dma_addr = da; dma_wdata = wd(da);
    it.tag = tag; it.cg = cg; it.dg = dg; it.cd = cd; it.dd = dd;
    it.vld = vld; it.own = own; it.cs = cs; it.ds = ds; it.cw = cw; it.dw = dw;
    it.ca = ca; it.da = da;
    q.push_back(it);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, 4'b0000);
  endtask

  // Monitor: pops one expected item per cycle and compares
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(it.tag, "cpu_gnt", 32'(cpu_gnt), 32'(it.cg));
        chk(it.tag, "dma_gnt", 32'(dma_gnt), 32'(it.dg));
        chk(it.tag, "cpu_done", 32'(cpu_done), 32'(it.cd));
        chk(it.tag, "dma_done", 32'(dma_done), 32'(it.dd));
        chk(it.tag, "slv_vld", 32'(slv_vld), 32'(it.vld));
        chk(it.tag, "slv_owner", 32'(slv_owner), 32'(it.own));
        chk("R6", "vld count vs grants", 32'($countones(slv_vld)),
            32'(int'(it.cg) + int'(it.dg)));
        for (int s = 0; s < NSLV; s++) begin
          if (it.vld[s]) begin
            chk(it.tag, "slv_addr", 32'(slv_addr[s*AW +: AW]),
                32'(it.own[s] ? it.da : it.ca));
            chk(it.tag, "slv_wdata", slv_wdata[s*DW +: DW],
                it.own[s] ? wd(it.da) : wd(it.ca));
            chk(it.tag, "slv_we", 32'(slv_we[s]), 32'(it.own[s] ? it.dw : it.cw));
          end
        end
        if (it.cd) chk("R7", "cpu_rdata", cpu_rdata, rd_val(int'(it.cs), it.ca));
        if (it.dd) chk("R7", "dma_rdata", dma_rdata, rd_val(int'(it.ds), it.da));
      end
    end
  end

  initial begin
    #(PER * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cpu_req = 0; cpu_sel = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    dma_req = 0; dma_sel = 0; dma_we = 0; dma_addr = 0; dma_wdata = 0;
    idle("R1");
    idle("R1");
    @(negedge clk);
    rst = 1'b0;
    idle("R1");

    // R2 R8: CPU reads peripheral, DMA writes USB in the same cycle
    cyc("R2", 1, 2'd1, 0, 16'h0101, 1, 2'd3, 1, 16'h0303, 1, 1, 0, 1, 4'b1010, 4'b1000);
    cyc("R8", 1, 2'd1, 0, 16'h0101, 0, 2'd0, 0, 16'h0000, 1, 0, 0, 0, 4'b0010, 4'b0000);
    cyc("R8", 1, 2'd1, 0, 16'h0101, 0, 2'd0, 0, 16'h0000, 1, 0, 1, 0, 4'b0010, 4'b0000);
    idle("R1");

    // R3 R4: both read RAM; CPU first, DMA waits then proceeds
    cyc("R3", 1, 2'd0, 0, 16'h0010, 1, 2'd0, 0, 16'h0020, 1, 0, 0, 0, 4'b0001, 4'b0000);
    cyc("R3", 1, 2'd0, 0, 16'h0010, 1, 2'd0, 0, 16'h0020, 1, 0, 1, 0, 4'b0001, 4'b0000);
    cyc("R4", 0, 2'd0, 0, 16'h0000, 1, 2'd0, 0, 16'h0020, 0, 1, 0, 0, 4'b0001, 4'b0001);
    cyc("R4", 0, 2'd0, 0, 16'h0000, 1, 2'd0, 0, 16'h0020, 0, 1, 0, 1, 4'b0001, 4'b0001);
    idle("R1");

    // R5 R10: DMA holds external bridge, CPU arrives mid-access
    cyc("R5", 0, 2'd0, 0, 16'h0000, 1, 2'd2, 0, 16'h0200, 0, 1, 0, 0, 4'b0100, 4'b0100);
    cyc("R5", 1, 2'd2, 0, 16'h0201, 1, 2'd2, 0, 16'h0200, 0, 1, 0, 0, 4'b0100, 4'b0100);
    cyc("R5", 1, 2'd2, 0, 16'h0201, 1, 2'd2, 0, 16'h0200, 0, 1, 0, 1, 4'b0100, 4'b0100);
    cyc("R10", 1, 2'd2, 0, 16'h0201, 0, 2'd0, 0, 16'h0000, 1, 0, 0, 0, 4'b0100, 4'b0000);
    cyc("R10", 1, 2'd2, 0, 16'h0201, 0, 2'd0, 0, 16'h0000, 1, 0, 0, 0, 4'b0100, 4'b0000);
    cyc("R10", 1, 2'd2, 0, 16'h0201, 0, 2'd0, 0, 16'h0000, 1, 0, 1, 0, 4'b0100, 4'b0000);
    idle("R1");

    // R9: DMA RAM read (2) then USB write (1) beside a CPU peripheral read
    cyc("R9", 1, 2'd1, 0, 16'h0111, 1, 2'd0, 0, 16'h0040, 1, 1, 0, 0, 4'b0011, 4'b0001);
    cyc("R9", 1, 2'd1, 0, 16'h0111, 1, 2'd0, 0, 16'h0040, 1, 1, 0, 1, 4'b0011, 4'b0001);
    cyc("R9", 1, 2'd1, 0, 16'h0111, 1, 2'd3, 1, 16'h0041, 1, 1, 1, 1, 4'b1010, 4'b1000);
    idle("R1");

    // R10: CPU abandons peripheral mid-access, DMA takes it at once
    cyc("R10", 1, 2'd1, 0, 16'h0120, 0, 2'd0, 0, 16'h0000, 1, 0, 0, 0, 4'b0010, 4'b0000);
    cyc("R10", 0, 2'd0, 0, 16'h0000, 1, 2'd1, 0, 16'h0121, 0, 1, 0, 0, 4'b0010, 4'b0010);
    idle("R1");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule